// File: doc/BRIEF.md
# PCI Command and Status Configuration Register

This block holds the 32-bit configuration word that joins a PCI function's command controls and its status flags. Software reaches it through a single-cycle write port with per-byte-lane enables and a combinational read bus. The command half holds the bus master, memory write and invalidate, fast back-to-back and parity response enables. It also holds the enable that lets parity problems reach the system error line. These enables leave the block as plain outputs so the bus engine can use them.

The status half reports fixed capability bits and one sticky flag. The flag records a data parity error seen while this function was the initiator of the failing transaction. The bus engine reports three kinds of event: a data parity error with a "we were master" qualifier, an address parity error, and a special-cycle data parity error. The block decides whether each event is recorded, signalled or dropped. When parity response is disabled, every event is discarded. Two straps, boot mode and host mode, set the reset value of the bus master enable.

Top module: `pci_cfg_cmdstat`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register resets to 0x00B0_0000, with bit 2 taken from R2, and `serr_n` resets high.
- R2: Bit 2 (bus master enable) resets to 1 only when `boot_strap` and `host_strap` are both 1 during reset. It resets to 0 otherwise, and a later write can change it.
- R3: Bits 9, 8, 6, 4 and 2 are read/write. A write updates a bit on the next clock edge only when the byte-lane enable for the bit's byte is set. Bits 9 and 8 are in lane 1, and bits 6, 4 and 2 are in lane 0.
- R4: Bits 23, 21 and 20 always read 1. Every other bit outside 24, 9, 8, 6, 4 and 2 always reads 0, and writes to any of these bits are ignored.
- R5: Bit 24 becomes 1 on the edge after a cycle in which `perr_seen`, `was_master` and bit 6 are all 1.
- R6: Bit 24 does not set when `was_master` is 0 or bit 6 is 0, even if `perr_seen` is 1.
- R7: Bit 24 clears when a write with lane 3 enabled carries 1 in bit 24. Writing 0 to bit 24, or writing with lane 3 disabled, leaves it unchanged.
- R8: If a clear of bit 24 and a set condition occur in the same cycle, bit 24 ends up 1.
- R9: `serr_n` is low for exactly the one cycle after each cycle in which `addr_perr` or `spc_perr` is 1 and bits 8 and 6 are both 1. Otherwise `serr_n` is high.
- R10: `bus_master_en`, `mwi_en`, `fbb_en` and `parity_resp_en` equal bits 2, 4, 9 and 6 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_strap | input | 1 | Boot-mode strap, sampled during reset |
| host_strap | input | 1 | Host-mode strap, sampled during reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| perr_seen | input | 1 | Data parity error detected in this cycle |
| was_master | input | 1 | This function was initiator of that transaction |
| addr_perr | input | 1 | Address parity error detected |
| spc_perr | input | 1 | Special-cycle data parity error detected |
| bus_master_en | output | 1 | Bus master enable |
| mwi_en | output | 1 | Memory write and invalidate enable |
| fbb_en | output | 1 | Fast back-to-back enable |
| parity_resp_en | output | 1 | Parity error response enable |
| serr_n | output | 1 | System error, active low |

## Verification
The assertions take the event inputs as single-cycle pulses that belong to the clock cycle in which they are high. They also assume `was_master` is meaningful only when `perr_seen` is 1. The checker relates each low cycle of `serr_n` and each rising edge of bit 24 to the register's own enable bits in the cycle before. This is valid only because the straps and events never change between edges. The bench drives every input at the falling edge and holds it for one full cycle. It samples at the next falling edge, so each event is seen by exactly one rising edge.

// File: rtl/pci_cfg_pkg.sv
// Package: pci_cfg_pkg
// Holds the bit positions and masks of the command/status word shared by
// the register, its submodules and the checker. Assumes a 32-bit word.
package pci_cfg_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;

    localparam int unsigned B_BM    = 2;
    localparam int unsigned B_MWI   = 4;
    localparam int unsigned B_PRESP = 6;
    localparam int unsigned B_SEEN  = 8;
    localparam int unsigned B_FBBE  = 9;
    localparam int unsigned B_MDPE  = 24;

    // Writable control bits.
    localparam logic [WORD_W-1:0] RW_MASK  = (32'd1 << B_BM) | (32'd1 << B_MWI) |
                                             (32'd1 << B_PRESP) | (32'd1 << B_SEEN) |
                                             (32'd1 << B_FBBE);
    // Capability bits tied high (bits 23, 21, 20).
    localparam logic [WORD_W-1:0] ONE_MASK = (32'd1 << 23) | (32'd1 << 21) | (32'd1 << 20);
    // Every bit whose value is fixed.
    localparam logic [WORD_W-1:0] FIX_MASK = ~(RW_MASK | (32'd1 << B_MDPE));
endpackage

// File: rtl/pci_cfg_ctrl.sv
// Module: pci_cfg_ctrl
// The read/write control bits of the word. One flop is built per bit set in
// RW_MASK; every other bit is a constant zero. Writes are qualified per byte
// lane. The reset value of each writable bit comes from rst_val, so the
// parent can feed the strap-derived bus master value.
module pci_cfg_ctrl
    import pci_cfg_pkg::*;
#(
    parameter int unsigned          W    = WORD_W,
    parameter logic [W-1:0]         MASK = RW_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     rst_val,
    input  logic             wr_en,
    input  logic [W/8-1:0]   wr_be,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     ctrl_q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (MASK[i]) begin : g_rw
                logic q;
                // Per-bit flop: reset value, then lane-qualified write.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q <= rst_val[i];
                    else if (wr_en && wr_be[i/8])
                        q <= wr_data[i];
                end
                assign ctrl_q[i] = q;
            end else begin : g_zero
                assign ctrl_q[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/pci_cfg_flag.sv
// Module: pci_cfg_flag
// Sticky write-1-to-clear flag. A set request dominates a clear in the same
// cycle. Assumes set_req already contains every gating condition.
module pci_cfg_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag_q
);
    // Flag state: set wins over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_req)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/pci_cfg_serr.sv
// Module: pci_cfg_serr
// Registers the active-low system error pulse. The line is low for one cycle
// after each cycle with a qualifying event, and high otherwise. Assumes the
// events are one-cycle pulses from the bus engine.
module pci_cfg_serr #(
    parameter int unsigned N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic             serr_enable,
    input  logic             resp_enable,
    output logic             serr_n
);
    logic fire;
    // Any source counts, but only with both enables set.
    always_comb fire = (|evt) && serr_enable && resp_enable;

    // Output register, released high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            serr_n <= 1'b1;
        else
            serr_n <= !fire;
    end
endmodule

// File: rtl/pci_cfg_cmdstat.sv
// Module: pci_cfg_cmdstat
// Top of the command/status configuration register. It combines the control
// flops, the sticky master data parity flag and the system error pulse, and
// assembles the read word. Assumes a synchronous active-low reset and straps
// that are stable while reset is held.
module pci_cfg_cmdstat
    import pci_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_strap,
    input  logic              host_strap,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              perr_seen,
    input  logic              was_master,
    input  logic              addr_perr,
    input  logic              spc_perr,
    output logic              bus_master_en,
    output logic              mwi_en,
    output logic              fbb_en,
    output logic              parity_resp_en,
    output logic              serr_n
);
    logic [WORD_W-1:0] rst_val;
    logic [WORD_W-1:0] ctrl_q;
    logic              mdpe_set;
    logic              mdpe_clr;
    logic              mdpe_q;

    // Reset value for the control bits: only bus master follows the straps.
    always_comb begin
        rst_val       = '0;
        rst_val[B_BM] = boot_strap && host_strap;
    end

    pci_cfg_ctrl #(.W(WORD_W), .MASK(RW_MASK)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (rst_val),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    // Flag gating: master-side data parity error with parity response on.
    always_comb begin
        mdpe_set = perr_seen && was_master && ctrl_q[B_PRESP];
        mdpe_clr = wr_en && wr_be[B_MDPE/8] && wr_data[B_MDPE];
    end

    pci_cfg_flag u_mdpe (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (mdpe_set),
        .clr_req (mdpe_clr),
        .flag_q  (mdpe_q)
    );

    pci_cfg_serr #(.N_SRC(2)) u_serr (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         ({spc_perr, addr_perr}),
        .serr_enable (ctrl_q[B_SEEN]),
        .resp_enable (ctrl_q[B_PRESP]),
        .serr_n      (serr_n)
    );

    // Read word: control flops, fixed ones, sticky flag.
    always_comb begin
        rd_data         = ctrl_q | ONE_MASK;
        rd_data[B_MDPE] = mdpe_q;
    end

    // Enable outputs taken from the control flops.
    always_comb begin
        bus_master_en  = ctrl_q[B_BM];
        mwi_en         = ctrl_q[B_MWI];
        fbb_en         = ctrl_q[B_FBBE];
        parity_resp_en = ctrl_q[B_PRESP];
    end
endmodule

// File: rtl/pci_cfg_cmdstat_chk.sv
// Module: pci_cfg_cmdstat_chk
// Property checker bound to pci_cfg_cmdstat. Observes ports only.
module pci_cfg_cmdstat_chk
    import pci_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] rd_data,
    input logic              wr_en,
    input logic              wr_be3,
    input logic              wr_d24,
    input logic              perr_seen,
    input logic              was_master,
    input logic              addr_perr,
    input logic              spc_perr,
    input logic              serr_n
);
    // R4: fixed bits hold their constant values.
    a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & FIX_MASK) == ONE_MASK);

    // R5: a qualified master-side error sets the flag on the next edge.
    a_r5_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_seen && was_master && rd_data[B_PRESP]) |=> rd_data[B_MDPE]);

    // R6: the flag rises only after a qualified cause.
    a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_MDPE]) |-> $past(perr_seen && was_master && rd_data[B_PRESP]));

    // R7: an uncontested write-1 clear empties the flag.
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be3 && wr_d24 && !(perr_seen && was_master && rd_data[B_PRESP]))
        |=> !rd_data[B_MDPE]);

    // R9: a qualified address or special-cycle error drives serr_n low next cycle.
    a_r9_serr_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_perr || spc_perr) && rd_data[B_SEEN] && rd_data[B_PRESP]) |=> !serr_n);

    // R9: serr_n is low only after a qualified event.
    a_r9_serr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past((addr_perr || spc_perr) && rd_data[B_SEEN] && rd_data[B_PRESP]));
endmodule

bind pci_cfg_cmdstat pci_cfg_cmdstat_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_be3     (wr_be[3]),
    .wr_d24     (wr_data[24]),
    .perr_seen  (perr_seen),
    .was_master (was_master),
    .addr_perr  (addr_perr),
    .spc_perr   (spc_perr),
    .serr_n     (serr_n)
);

// File: tb/pci_cfg_cmdstat_test.sv
module pci_cfg_cmdstat_test;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic        we;
        logic [31:0] wd;
        logic [3:0]  be;
        logic        perr;
        logic        mst;
        logic        aerr;
        logic        serr_e;
        logic [31:0] exp_rd;
        logic        exp_serr_n;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'hFFFF_FFFF, 4'hF, 1'b0,1'b0,1'b0,1'b0, 32'h00B0_0354, 1'b1}, // R3 R4 all lanes
        '{1'b0, 32'h0,         4'h0, 1'b1,1'b1,1'b0,1'b0, 32'h01B0_0354, 1'b1}, // R5 set
        '{1'b1, 32'h0,         4'hF, 1'b0,1'b0,1'b0,1'b0, 32'h01B0_0000, 1'b1}, // R7 write 0 holds
        '{1'b1, 32'h0100_0000, 4'h7, 1'b0,1'b0,1'b0,1'b0, 32'h01B0_0000, 1'b1}, // R7 lane 3 off
        '{1'b1, 32'h0100_0000, 4'h8, 1'b0,1'b0,1'b0,1'b0, 32'h00B0_0000, 1'b1}, // R7 clear
        '{1'b1, 32'h0000_0040, 4'h1, 1'b0,1'b0,1'b0,1'b0, 32'h00B0_0040, 1'b1}, // R3 lane 0
        '{1'b0, 32'h0,         4'h0, 1'b1,1'b0,1'b0,1'b0, 32'h00B0_0040, 1'b1}, // R6 target only
        '{1'b0, 32'h0,         4'h0, 1'b0,1'b0,1'b1,1'b0, 32'h00B0_0040, 1'b1}, // R9 serr enable off
        '{1'b1, 32'h0000_0100, 4'h2, 1'b0,1'b0,1'b0,1'b0, 32'h00B0_0140, 1'b1}, // R3 lane 1
        '{1'b0, 32'h0,         4'h0, 1'b0,1'b0,1'b1,1'b0, 32'h00B0_0140, 1'b0}, // R9 address error
        '{1'b0, 32'h0,         4'h0, 1'b0,1'b0,1'b0,1'b1, 32'h00B0_0140, 1'b0}, // R9 special cycle
        '{1'b0, 32'h0,         4'h0, 1'b0,1'b0,1'b0,1'b0, 32'h00B0_0140, 1'b1}, // R9 released
        '{1'b1, 32'h0,         4'h1, 1'b0,1'b0,1'b0,1'b0, 32'h00B0_0100, 1'b1}, // R3 response off
        '{1'b0, 32'h0,         4'h0, 1'b1,1'b1,1'b1,1'b0, 32'h00B0_0100, 1'b1}, // R6 R9 ignored
        '{1'b1, 32'h0000_0040, 4'h1, 1'b0,1'b0,1'b0,1'b0, 32'h00B0_0140, 1'b1}, // R3
        '{1'b1, 32'h0100_0000, 4'h8, 1'b1,1'b1,1'b0,1'b0, 32'h01B0_0140, 1'b1}, // R8 set wins
        '{1'b1, 32'h0000_0214, 4'h3, 1'b0,1'b0,1'b0,1'b0, 32'h01B0_0214, 1'b1}  // R3 R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_strap = 1'b1;
    logic        host_strap = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        perr_seen = 1'b0;
    logic        was_master = 1'b0;
    logic        addr_perr = 1'b0;
    logic        spc_perr = 1'b0;
    logic        bus_master_en, mwi_en, fbb_en, parity_resp_en, serr_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cfg_cmdstat uut (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .host_strap(host_strap),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
        .perr_seen(perr_seen), .was_master(was_master), .addr_perr(addr_perr),
        .spc_perr(spc_perr), .bus_master_en(bus_master_en), .mwi_en(mwi_en),
        .fbb_en(fbb_en), .parity_resp_en(parity_resp_en), .serr_n(serr_n)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic b, input logic h);
        @(negedge clk);
        boot_strap = b; host_strap = h; rst_n = 1'b0;
        wr_en = 1'b0; perr_seen = 1'b0; was_master = 1'b0; addr_perr = 1'b0; spc_perr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1 R2: reset with only the boot strap set.
        do_reset(1'b1, 1'b0);
        check32("R1 reset word", rd_data, 32'h00B0_0000);
        check32("R1 serr_n reset", {31'd0, serr_n}, 32'd1);
        check32("R2 bm one strap", {31'd0, bus_master_en}, 32'd0);

        // Table walk: drive at negedge, check at the following negedge.
        for (int k = 0; k < NV; k++) begin
            wr_en = VEC[k].we; wr_data = VEC[k].wd; wr_be = VEC[k].be;
            perr_seen = VEC[k].perr; was_master = VEC[k].mst;
            addr_perr = VEC[k].aerr; spc_perr = VEC[k].serr_e;
            @(negedge clk);
            check32($sformatf("vector %0d rd_data", k), rd_data, VEC[k].exp_rd);
            check32($sformatf("vector %0d serr_n", k), {31'd0, serr_n}, {31'd0, VEC[k].exp_serr_n});
        end
        wr_en = 1'b0; perr_seen = 1'b0; was_master = 1'b0;

        // R10: enable outputs follow the written bits 2, 4, 9 and 6.
        check32("R10 enables", {28'd0, bus_master_en, mwi_en, fbb_en, parity_resp_en},
                {28'd0, 1'b1, 1'b1, 1'b1, 1'b0});

        // R2: both straps set give bus master 1 after reset.
        do_reset(1'b1, 1'b1);
        check32("R2 bm both straps", rd_data, 32'h00B0_0004);
        check32("R2 bm output", {31'd0, bus_master_en}, 32'd1);
        // R2: software can clear it later.
        wr_en = 1'b1; wr_be = 4'h1; wr_data = 32'h0;
        @(negedge clk);
        wr_en = 1'b0;
        check32("R2 bm overwritten", rd_data, 32'h00B0_0000);

        // R9: back-to-back enable write then a single event gives one low cycle.
        wr_en = 1'b1; wr_be = 4'h3; wr_data = 32'h0000_0140;
        @(negedge clk);
        wr_en = 1'b0; addr_perr = 1'b1;
        @(negedge clk);
        addr_perr = 1'b0;
        check32("R9 single pulse low", {31'd0, serr_n}, 32'd0);
        @(negedge clk);
        check32("R9 single pulse released", {31'd0, serr_n}, 32'd1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule